// File: doc/BRIEF.md
# Signaling Change Event Queue with Interrupt Controller

This block holds change-of-signaling-state events in a small first-in first-out queue and raises interrupts from the queue's condition. A producer pushes event words through a write strobe. A host drains them through a read strobe, and the oldest word is always visible on the read data port. Three sticky interrupt bits watch the queue. The first latches when occupancy rises above a programmable threshold. The second latches when a programmable timer runs out while events are waiting. The third latches when a write arrives at a full queue.

Each sticky bit has its own mask, and the combined interrupt line is the OR of the unmasked sticky bits. A global mode input selects how the host clears the bits. In clear-on-read mode, a read strobe on the interrupt register clears all of them. Otherwise, the host writes ones to the bits it wants cleared. A live, non-sticky status output shows whether occupancy is above the threshold at this moment.

Top module: `sigq_irq_ctrl`

## Requirements
- R1: Words leave in the order they were written; `rd_data` shows the oldest stored word whenever `empty` is 0; a read strobe while empty changes nothing.
- R2: A write while the queue holds DEPTH words is dropped and the stored words are kept; the overflow bit, `irq_sticky[2]`, is 1 from the next clock edge on.
- R3: `thr_status` is 1 exactly while the current occupancy is strictly greater than `thresh`.
- R4: The threshold bit, `irq_sticky[0]`, becomes 1 at the clock edge that follows any cycle in which `thr_status` is 1.
- R5: The timer counter loads `tmr_reload` on every edge at which the queue is empty or the counter is zero, and otherwise counts down by one. A cycle with a zero counter and a non-empty queue is an expiry, and the timer bit, `irq_sticky[1]`, is 1 from the next edge on.
- R6: A sticky bit stays 1 until it is cleared; a set condition in the same cycle as a clear leaves the bit at 1.
- R7: With `cor_en` = 1, an `irq_rd` strobe clears all three sticky bits at the next edge, and `clr_wr` has no effect.
- R8: With `cor_en` = 0, `irq_rd` has no effect, and `clr_wr` clears exactly the sticky bits whose `clr_bits` are 1.
- R9: `irq_out` is 1 exactly when some sticky bit is 1 and its `irq_mask` bit is 0 (1 masks that bit).
- R10: After reset the queue is empty, all sticky bits are 0 and `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push an event word |
| wr_data | input | DW | Event word to push |
| rd_en | input | 1 | Pop the oldest word |
| rd_data | output | DW | Oldest stored word |
| empty | output | 1 | Queue holds no word |
| thresh | input | CW | Occupancy threshold |
| tmr_reload | input | TW | Timer reload value |
| irq_mask | input | 3 | Mask per sticky bit, 1 masks |
| cor_en | input | 1 | 1 selects clear-on-read |
| irq_rd | input | 1 | Read strobe of the interrupt register |
| clr_wr | input | 1 | Write strobe for write-one-to-clear |
| clr_bits | input | 3 | Bits to clear on `clr_wr` |
| irq_sticky | output | 3 | Sticky bits: [0] threshold, [1] timer, [2] overflow |
| thr_status | output | 1 | Live occupancy-above-threshold status |
| irq_out | output | 1 | Combined interrupt line |

## Verification
`rd_data`, `empty`, `thr_status` and `irq_out` follow the registered state combinationally. They are due in the same cycle as the edge that changed the occupancy, or at once when `thresh` or `irq_mask` changes. Each sticky bit is due one edge after its cause: an overflowing write, a cycle above the threshold, or an expiry. An expiry comes `tmr_reload` edges after the edge that makes the queue non-empty. The bench drives inputs on the falling edge and compares every output one time unit later against a reference model. That model is advanced only at the rising edge, so each check sees exactly the state after the registers on the path have updated.

// File: rtl/sigq_pkg.sv
package sigq_pkg;

    localparam int IRQ_N = 3;

    // bit 2: overflow, bit 1: timer, bit 0: threshold
    typedef struct packed {
        logic ovf;
        logic tmr;
        logic thr;
    } irq_vec_t;

    function automatic irq_vec_t clear_select(
        input logic     cor,
        input logic     rd_stb,
        input logic     wr_stb,
        input irq_vec_t wr_bits
    );
        irq_vec_t c;
        if (cor)
            c = rd_stb ? '1 : '0;
        else
            c = wr_stb ? wr_bits : '0;
        return c;
    endfunction

endpackage

// File: rtl/sigq_fifo.sv
module sigq_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          ovf_evt
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_wr, do_rd;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign ovf_evt = wr_en && full;
    assign rd_data = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= bump(wptr);
            if (do_rd) rptr <= bump(rptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en) |=> (count == $past(count))); // R2
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !wr_en) |=> empty); // R1
endmodule

// File: rtl/sigq_timer.sv
module sigq_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] reload,
    input  logic          empty,
    output logic          expire
);
    logic [TW-1:0] cnt;

    assign expire = !empty && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (empty || cnt == '0)
            cnt <= reload;
        else
            cnt <= cnt - 1'b1;
    end

    AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (rst)
        empty |=> (cnt == $past(reload))); // R5
endmodule

// File: rtl/sigq_irq.sv
module sigq_irq
    import sigq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t set,
    input  logic     cor_en,
    input  logic     irq_rd,
    input  logic     clr_wr,
    input  irq_vec_t clr_bits,
    input  irq_vec_t mask,
    output irq_vec_t sticky,
    output logic     irq_out
);
    irq_vec_t clr;

    assign clr     = clear_select(cor_en, irq_rd, clr_wr, clr_bits);
    assign irq_out = |(sticky & ~mask);

    always_ff @(posedge clk) begin
        if (rst)
            sticky <= '0;
        else
            sticky <= (sticky & ~clr) | set;
    end

    for (genvar i = 0; i < IRQ_N; i++) begin : g_chk
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
            (sticky[i] && !clr[i]) |=> sticky[i]); // R6
        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> sticky[i]); // R6
    end

    AST_COR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cor_en && irq_rd && set == '0) |=> (sticky == '0)); // R7
endmodule

// File: rtl/sigq_irq_ctrl.sv
module sigq_irq_ctrl
    import sigq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int TW    = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    input  logic [CW-1:0] thresh,
    input  logic [TW-1:0] tmr_reload,
    input  logic [2:0]    irq_mask,
    input  logic          cor_en,
    input  logic          irq_rd,
    input  logic          clr_wr,
    input  logic [2:0]    clr_bits,
    output logic [2:0]    irq_sticky,
    output logic          thr_status,
    output logic          irq_out
);
    logic [CW-1:0] count;
    logic          full, ovf_evt, expire;
    irq_vec_t      set, sticky;

    sigq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data),
        .count(count), .empty(empty), .full(full), .ovf_evt(ovf_evt)
    );

    sigq_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst(rst),
        .reload(tmr_reload), .empty(empty), .expire(expire)
    );

    assign thr_status = (count > thresh);
    assign set        = '{ovf: ovf_evt, tmr: expire, thr: thr_status};

    sigq_irq u_irq (
        .clk(clk), .rst(rst),
        .set(set), .cor_en(cor_en), .irq_rd(irq_rd),
        .clr_wr(clr_wr), .clr_bits(irq_vec_t'(clr_bits)),
        .mask(irq_vec_t'(irq_mask)),
        .sticky(sticky), .irq_out(irq_out)
    );

    assign irq_sticky = sticky;

    AST_THR_LATCH: assert property (@(posedge clk) disable iff (rst)
        thr_status |=> irq_sticky[0]); // R4
    AST_OVF_LATCH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> irq_sticky[2]); // R2
endmodule

// File: tb/test_sigq_irq_ctrl.sv
module test_sigq_irq_ctrl;
    localparam int CLK_P = 10;
    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int TW    = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 0, rst = 1;
    logic          wr_en = 0, rd_en = 0, cor_en = 0, irq_rd = 0, clr_wr = 0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] thresh = '0;
    logic [TW-1:0] tmr_reload = '0;
    logic [2:0]    irq_mask = '0, clr_bits = '0;
    logic [DW-1:0] rd_data;
    logic          empty, thr_status, irq_out;
    logic [2:0]    irq_sticky;

    int    n_run = 0, n_fail = 0;
    bit    done = 0;
    string ph = "R10 reset";

    // reference model
    int         mq[$];
    int         m_tmr = 0;
    logic [2:0] m_stk = '0;

    always #(CLK_P/2) clk = ~clk;

    sigq_irq_ctrl #(.DW(DW), .DEPTH(DEPTH), .TW(TW)) i_sigq_irq_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty),
        .thresh(thresh), .tmr_reload(tmr_reload), .irq_mask(irq_mask),
        .cor_en(cor_en), .irq_rd(irq_rd), .clr_wr(clr_wr), .clr_bits(clr_bits),
        .irq_sticky(irq_sticky), .thr_status(thr_status), .irq_out(irq_out)
    );

    function automatic logic [2:0] exp_clear();
        if (cor_en) return irq_rd ? 3'b111 : 3'b000;
        return clr_wr ? clr_bits : 3'b000;
    endfunction

    task automatic model_edge();
        logic [2:0] s;
        bit full, emp;
        if (rst) begin
            mq.delete(); m_tmr = 0; m_stk = '0;
            return;
        end
        full = (mq.size() == DEPTH);
        emp  = (mq.size() == 0);
        s[0] = (mq.size() > int'(thresh));
        s[1] = !emp && (m_tmr == 0);
        s[2] = wr_en && full;
        m_stk = (m_stk & ~exp_clear()) | s;
        if (emp || m_tmr == 0) m_tmr = int'(tmr_reload);
        else m_tmr--;
        if (rd_en && !emp) void'(mq.pop_front());
        if (wr_en && !full) mq.push_back(int'(wr_data));
    endtask

    task automatic chk(string what, int act, int expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", ph, what, act, expv);
        end
    endtask

    task automatic compare();
        logic [2:0] mk;
        mk = m_stk & ~irq_mask;
        chk("empty R1", int'(empty), int'(mq.size() == 0));
        if (mq.size() != 0) chk("rd_data R1", int'(rd_data), mq[0]);
        chk("thr_status R3", int'(thr_status), int'(mq.size() > int'(thresh)));
        chk("sticky[0] R4", int'(irq_sticky[0]), int'(m_stk[0]));
        chk("sticky[1] R5", int'(irq_sticky[1]), int'(m_stk[1]));
        chk("sticky[2] R2", int'(irq_sticky[2]), int'(m_stk[2]));
        chk("irq_out R9", int'(irq_out), int'(|mk));
    endtask

    task automatic cyc();
        #1 compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle_in();
        wr_en = 0; rd_en = 0; irq_rd = 0; clr_wr = 0; clr_bits = '0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        rst = 1; tmr_reload = 16'd1000; thresh = 5'd3;
        repeat (3) begin @(posedge clk); model_edge(); @(negedge clk); end
        rst = 0;
        ph = "R10 reset";
        cyc();

        // fill past full: threshold, ordering, overflow drop
        ph = "R2 R4 fill";
        for (int i = 0; i < DEPTH + 2; i++) begin
            wr_en = 1; wr_data = DW'(i * 7 + 1);
            cyc();
        end
        idle_in(); cyc();
        ph = "R1 drain";
        for (int i = 0; i < DEPTH + 2; i++) begin
            rd_en = 1; cyc();
        end
        idle_in(); cyc();

        // w1c mode: read does nothing, w1c clears selected
        ph = "R8 read no effect";
        cor_en = 0; irq_rd = 1; cyc(); idle_in(); cyc();
        ph = "R8 w1c selected";
        clr_wr = 1; clr_bits = 3'b100; cyc(); idle_in(); cyc();
        clr_wr = 1; clr_bits = 3'b001; cyc(); idle_in(); cyc();

        // timer expiry with pending data
        ph = "R5 timer";
        tmr_reload = 16'd4;
        wr_en = 1; wr_data = 8'hA5; cyc(); idle_in();
        for (int i = 0; i < 8; i++) cyc();
        ph = "R6 set wins";
        clr_wr = 1; clr_bits = 3'b010; cyc(); idle_in();
        for (int i = 0; i < 6; i++) cyc();
        rd_en = 1; cyc(); idle_in(); cyc();

        // clear-on-read mode
        ph = "R7 clear-on-read";
        cor_en = 1;
        clr_wr = 1; clr_bits = 3'b111; cyc(); idle_in(); cyc();
        irq_rd = 1; cyc(); idle_in(); cyc();

        // masking
        ph = "R9 mask";
        thresh = 5'd0; tmr_reload = 16'd1000;
        wr_en = 1; wr_data = 8'h3C; cyc(); idle_in(); cyc();
        for (int m = 0; m < 8; m++) begin irq_mask = 3'(m); cyc(); end
        irq_mask = '0;
        rd_en = 1; cyc(); idle_in(); irq_rd = 1; cyc(); idle_in(); cyc();

        // read on empty
        ph = "R1 empty read";
        rd_en = 1; cyc(); cyc(); idle_in(); cyc();

        // constrained random
        ph = "random R1 R2 R3 R4 R5 R6 R7 R8 R9";
        for (int i = 0; i < 4000; i++) begin
            if (i % 200 == 0) begin
                thresh     = CW'($urandom_range(0, DEPTH));
                tmr_reload = TW'($urandom_range(0, 12));
                cor_en     = 1'($urandom_range(0, 1));
            end
            wr_en    = ($urandom_range(0, 99) < ((i / 500) % 2 ? 70 : 35));
            wr_data  = DW'($urandom);
            rd_en    = ($urandom_range(0, 99) < 45);
            irq_rd   = ($urandom_range(0, 99) < 10);
            clr_wr   = ($urandom_range(0, 99) < 10);
            clr_bits = 3'($urandom);
            irq_mask = 3'($urandom);
            cyc();
        end
        idle_in(); cyc();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule